// File: doc/BRIEF.md
# Serial DAC Word Loader with Daisy-Chain Output

This block is the synchronous serial front end of a 16-bit digital-to-analog converter. A host shifts a word in one bit per rising edge of a serial clock, most significant bit first. A rising edge on an update strobe then copies the assembled word into the holding register that drives the converter. The bit leaving the far end of the shift register appears on a serial output. Several loaders can therefore be chained, and a single host stream of 16 bits per device fills the whole chain before one shared strobe.

The serial clock and the update strobe are foreign to the block. They pass through a synchroniser into the single system clock domain, together with the data line so that all three keep their alignment. A small controller with three states sequences the update. In `ST_IDLE` serial clock edges shift, and a high strobe takes the transition `IDLE->LOAD`. `ST_LOAD` writes the holding register for one cycle and always takes `LOAD->HELD`. `ST_HELD` blocks shifting until the strobe falls, then takes `HELD->IDLE`. An asynchronous zero request forces the code to the bottom of span at once and keeps it there after release. It does not disturb the shift register.

Top module: `serial_dac_loader`

## Requirements
- R1: After reset `dac_code` is 0x0000 (bottom of span) and `ser_dout` is 0.
- R2: Sixteen serial-clock rising edges followed by a strobe rising edge make `dac_code` equal the sixteen sampled bits, the first sampled bit landing in bit 15.
- R3: `ser_dout` always shows the bit that the next serial-clock edge pushes out. After a full word it equals that word's bit 15, and after one more edge it equals bit 14.
- R4: `dac_code` changes only on an update; further shifting without a strobe leaves it unchanged.
- R5: Serial-clock edges that occur while the strobe is high are ignored. Neither the shift register nor `ser_dout` changes.
- R6: While `zero_req` is high, `dac_code` is 0x0000 within the same cycle, with no clock edge needed.
- R7: `zero_req` leaves the shift register unchanged, so a strobe after release loads the word shifted in before the request.
- R8: After `zero_req` falls, `dac_code` stays 0x0000 until the next strobe rising edge.
- R9: A strobe rising edge while `zero_req` is high has no effect on `dac_code`, which stays 0x0000 after release.
- R10: With `ser_dout` of one loader driving `ser_din` of a second, 32 bits followed by a shared strobe put the first 16 bits in the second loader and the last 16 in the first.
- R11: With inputs changed between clock edges, `ser_dout` changes on the third system clock edge after a serial-clock rise, and `dac_code` changes on the fourth edge after a strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; data sampled on its rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| upd_strobe | input | 1 | Update strobe; rising edge loads the holding register |
| zero_req | input | 1 | Asynchronous force of the code to bottom of span |
| dac_code | output | 16 | Code presented to the converter |
| ser_dout | output | 1 | Bit leaving the shift register, for chaining |

## Verification
A serial-clock or strobe change driven between edges passes two synchroniser stages. The edge decision is registered on the third edge, so `ser_dout` moves there and `dac_code` one edge later, through the `ST_LOAD` cycle. The timing test counts edges one at a time and samples one time unit after each edge. It confirms the old value on the edge before each result is due and the new value on the edge where it is due. Elsewhere the bench holds each serial level for four system clocks and waits six after a strobe change before sampling. These windows exceed the four-edge latency. The zero request acts without any edge and is sampled one time unit after it is driven.

// File: rtl/serial_dac_loader_pkg.sv
package serial_dac_loader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_HELD = 2'd2
    } ctl_state_t;

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [STAGES-1:0][N-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] word,
    output logic             dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WIDTH-2:0], din};
    end

    assign dout = word[WIDTH-1];

endmodule

// File: rtl/update_ctrl.sv
module update_ctrl
    import serial_dac_loader_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_q,
    input  logic       bit_rise,
    output logic       shift_en,
    output logic       load_en,
    output ctl_state_t state
);

    ctl_state_t nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (strobe_q)  nxt = ST_LOAD;
            ST_LOAD:                nxt = ST_HELD;
            ST_HELD: if (!strobe_q) nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        shift_en = 1'b0;
        load_en  = 1'b0;
        unique case (state)
            ST_IDLE: shift_en = bit_rise && !strobe_q;
            ST_LOAD: load_en  = 1'b1;
            ST_HELD: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/code_hold.sv
module code_hold #(
    parameter int unsigned    WIDTH       = 16,
    parameter logic [WIDTH-1:0] BOTTOM_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_req,
    input  logic             load_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] code
);

    logic hold_n;
    assign hold_n = rst_n & ~zero_req;

    always_ff @(posedge clk or negedge hold_n) begin
        if (!hold_n)      code <= BOTTOM_CODE;
        else if (load_en) code <= din;
    end

endmodule

// File: rtl/serial_dac_loader.sv
module serial_dac_loader
    import serial_dac_loader_pkg::*;
#(
    parameter int unsigned      WIDTH       = 16,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] BOTTOM_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_din,
    input  logic             upd_strobe,
    input  logic             zero_req,
    output logic [WIDTH-1:0] dac_code,
    output logic             ser_dout
);

    localparam int unsigned NSYNC = 3;

    logic [NSYNC-1:0] raw_in, synced;
    logic             sclk_q, sdin_q, strobe_q, sclk_prev, bit_rise;
    logic             shift_en, load_en;
    logic [WIDTH-1:0] shift_word;
    ctl_state_t       ctl_state;

    assign raw_in = {ser_clk, ser_din, upd_strobe};

    sync_chain #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(synced)
    );

    assign {sclk_q, sdin_q, strobe_q} = synced;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_q;
    end

    assign bit_rise = sclk_q & ~sclk_prev;

    update_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe_q(strobe_q), .bit_rise(bit_rise),
        .shift_en(shift_en), .load_en(load_en), .state(ctl_state)
    );

    shift_chain #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(sdin_q),
        .word(shift_word), .dout(ser_dout)
    );

    code_hold #(.WIDTH(WIDTH), .BOTTOM_CODE(BOTTOM_CODE)) u_hold (
        .clk(clk), .rst_n(rst_n), .zero_req(zero_req), .load_en(load_en),
        .din(shift_word), .code(dac_code)
    );

endmodule

// File: rtl/serial_dac_loader_chk.sv
module serial_dac_loader_chk
    import serial_dac_loader_pkg::*;
#(
    parameter int unsigned      WIDTH       = 16,
    parameter logic [WIDTH-1:0] BOTTOM_CODE = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             zero_req,
    input logic [WIDTH-1:0] dac_code,
    input logic             ser_dout,
    input logic [WIDTH-1:0] shift_word,
    input logic             shift_en,
    input logic             load_en,
    input ctl_state_t       state
);

    assert_shift_exposes_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> ser_dout == $past(shift_word[WIDTH-2]));

    assert_load_copies_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !zero_req) |=> (zero_req || dac_code == $past(shift_word)));

    assert_code_moves_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n || zero_req)
        (dac_code != $past(dac_code)) |-> $past(load_en));

    assert_frozen_outside_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(shift_word));

    assert_exclusive_actions_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_en, load_en}));

    assert_zero_forces_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |-> dac_code == BOTTOM_CODE);

endmodule

bind serial_dac_loader serial_dac_loader_chk #(.WIDTH(WIDTH), .BOTTOM_CODE(BOTTOM_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .zero_req(zero_req), .dac_code(dac_code),
    .ser_dout(ser_dout), .shift_word(shift_word), .shift_en(shift_en),
    .load_en(load_en), .state(ctl_state)
);

// File: tb/serial_dac_loader_tb.sv
module serial_dac_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_din = 1'b0, upd_strobe = 1'b0, zero_req = 1'b0;
    logic [15:0] near_code, far_code;
    logic        near_dout, far_dout;
    int          n_checks = 0, n_fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    serial_dac_loader u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .upd_strobe(upd_strobe), .zero_req(zero_req),
        .dac_code(near_code), .ser_dout(near_dout)
    );

    serial_dac_loader u_far (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(near_dout),
        .upd_strobe(upd_strobe), .zero_req(zero_req),
        .dac_code(far_code), .ser_dout(far_dout)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) begin ser_din = b; ser_clk = 1'b0; end
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_strobe();
        @(negedge clk) upd_strobe = 1'b1;
        repeat (6) @(negedge clk);
        upd_strobe = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        check("R1 code after reset", near_code, 16'h0000);
        check("R1 dout after reset", {15'd0, near_dout}, 16'h0000);
    endtask

    task automatic t_load();
        send_word(16'hA5C3); pulse_strobe();
        check("R2 load A5C3", near_code, 16'hA5C3);
        send_word(16'hFFFF); pulse_strobe();
        check("R2 load FFFF", near_code, 16'hFFFF);
        send_word(16'h0000); pulse_strobe();
        check("R2 load 0000", near_code, 16'h0000);
        send_word(16'h1234); pulse_strobe();
        check("R2 load 1234", near_code, 16'h1234);
    endtask

    task automatic t_dout_and_hold();
        send_word(16'h8001);
        check("R3 dout is bit15", {15'd0, near_dout}, 16'h0001);
        check("R4 code held while shifting", near_code, 16'h1234);
        send_bit(1'b1); repeat (4) @(negedge clk);
        check("R3 dout is bit14", {15'd0, near_dout}, 16'h0000);
        check("R4 code still held", near_code, 16'h1234);
    endtask

    task automatic t_ignore_while_strobe();
        send_word(16'h1357); pulse_strobe();
        check("R2 load 1357", near_code, 16'h1357);
        @(negedge clk) upd_strobe = 1'b1;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 16; i++) send_bit(1'b1);
        repeat (4) @(negedge clk);
        check("R5 dout unchanged under strobe", {15'd0, near_dout}, 16'h0000);
        upd_strobe = 1'b0;
        repeat (6) @(negedge clk);
        pulse_strobe();
        check("R5 register kept word", near_code, 16'h1357);
    endtask

    task automatic t_zero();
        send_word(16'h2468); pulse_strobe();
        check("R2 load 2468", near_code, 16'h2468);
        @(negedge clk) zero_req = 1'b1;
        #1 check("R6 zero immediate", near_code, 16'h0000);
        pulse_strobe();
        check("R9 strobe during zero ignored", near_code, 16'h0000);
        @(negedge clk) zero_req = 1'b0;
        repeat (10) @(negedge clk);
        check("R9 zero kept after release", near_code, 16'h0000);
        check("R8 bottom held after release", near_code, 16'h0000);
        pulse_strobe();
        check("R7 shift register preserved", near_code, 16'h2468);
    endtask

    task automatic t_timing();
        send_word(16'hBEEF);
        @(negedge clk) upd_strobe = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R11 code not yet on edge 3", near_code, 16'h2468);
        @(posedge clk);
        #1 check("R11 code on edge 4", near_code, 16'hBEEF);
        @(negedge clk) upd_strobe = 1'b0;
        repeat (6) @(negedge clk);
        check("R11 dout before rise", {15'd0, near_dout}, 16'h0001);
        @(negedge clk) begin ser_din = 1'b0; ser_clk = 1'b1; end
        repeat (2) @(posedge clk);
        #1 check("R11 dout not yet on edge 2", {15'd0, near_dout}, 16'h0001);
        @(posedge clk);
        #1 check("R11 dout on edge 3", {15'd0, near_dout}, 16'h0000);
        @(negedge clk) ser_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_chain();
        send_word(16'h1111);
        send_word(16'h2222);
        pulse_strobe();
        check("R10 far gets first word", far_code, 16'h1111);
        check("R10 near gets second word", near_code, 16'h2222);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_dout_and_hold();
        t_ignore_while_strobe();
        t_zero();
        t_timing();
        t_chain();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule